// File: doc/BRIEF.md
# Servo Pulse Timer with Period and Duty Match Channels

The block is a pulse-width timer for hobby servos and similar loads that want a fixed repetition rate (typically 20 ms at a 1 MHz tick) and a per-channel high time. One free-running counter is compared against a period match register (channel 0) and six duty match registers (channels 1 to 6). The counter advances once per clock and wraps to zero on the period match.

Software writes duty values into shadow copies. A value only reaches the working register at a period rollover, and only after its arm bit has been set. Loading a new value therefore never truncates or stretches the pulse already in progress. Each match can raise a write-one-to-clear flag, and the flags feed one interrupt line. A channel may also drive its own output pin. The pin goes high at the start of each period and low at the duty match.

Top module: `servo_match_timer`

## Requirements
- R1: During and right after reset, every pin output is low, every flag is clear, the interrupt line is low, the period register holds RST_PERIOD and all duty values are 0.
- R2: The counter steps by one per clock. On the clock after it reaches or passes the period value it reads 0, so one period lasts period+1 clocks.
- R3: A duty written at address n (1 to 6) is held in a shadow register. The shadow is copied to the working register only at a rollover while arm bit n (write to address 7, data bit n) is set. Arm bits clear at that rollover. An arm write landing on the rollover edge takes effect at the following rollover. A duty write in mid-period leaves the pulse in progress unchanged.
- R4: An enabled pin is high from count 0 up to count duty-1, giving a pulse of exactly `duty` clocks.
- R5: A duty of 0 keeps the pin low for the whole period. A duty equal to or above the period keeps it high for all period+1 clocks.
- R6: Data bit 8+n of the write to address 9 enables pin drive for channel n. A disabled pin stays low.
- R7: Data bit 3·n of the write to address 8 enables flag n. A match on channel n sets flag n only while that enable is set. The period match is match 0.
- R8: The `match_flags` output holds flag n at bit n for n = 0..3 and at bit n+4 for n = 4..6. Bits 4 to 7 are always 0.
- R9: Writing to address 10 clears each flag whose bit (R8 layout) is 1 and leaves flags with a 0 bit untouched. A match and a clear of the same flag on the same edge leave the flag set.
- R10: `irq` is high exactly when some flag is set whose enable is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one counter tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address for writes |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| pwm_out | output | 6 | Pin drive; bit i belongs to channel i+1 |
| match_flags | output | 11 | Match flags in the split layout of R8 |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of actions can fall on the same clock edge. The first pair is a flag being set by its match while software clears it. The second is an arm write arriving on the very edge where the counter wraps. The bench locks onto the period start through flag 0 and counts clocks from there, so that the clear write lands on the edge where channel 1 matches. It expects the flag to survive. It then places an arm write on the wrap edge and expects the old pulse width to persist for one more period. A scoreboard of pulse widths also confirms that duty writes made during a pulse only show from the next period on.

// File: rtl/servo_timer_pkg.sv
// Shared constants for the servo match timer: channel count, register
// addresses and the mapping of match index to flag bit position.
// Assumes at most 6 duty channels so that the split flag layout fits 11 bits.
package servo_timer_pkg;
    localparam int NUM_DUTY = 6;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int FLAG_W   = 11;

    localparam logic [ADDR_W-1:0] ADR_PERIOD   = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_ARM      = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_IRQ_EN   = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_PIN_EN   = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_FLAG_CLR = 4'd10;

    // Bit of match_flags that carries flag n (0 = period match)
    function automatic int flag_bit(int n);
        return (n <= 3) ? n : n + 4;
    endfunction
endpackage

// File: rtl/servo_timer_regs.sv
// Register file: period, duty shadows, arm bits, flag enables, pin enables
// and the decoded write-one-to-clear pulses. Arm bits self-clear at rollover.
// Assumes CNT_W <= DATA_W and that one write arrives per cycle at most.
module servo_timer_regs
    import servo_timer_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RST_PERIOD = 19999
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic                           we_i,
    input  logic                           rollover_i,
    output logic [CNT_W-1:0]               period_o,
    output logic [NUM_DUTY-1:0][CNT_W-1:0] shadow_o,
    output logic [NUM_DUTY-1:0]            arm_o,
    output logic [NUM_DUTY:0]              irq_en_o,
    output logic [NUM_DUTY-1:0]            pin_en_o,
    output logic [NUM_DUTY:0]              flag_clr_o
);
    logic                arm_wr;
    logic [NUM_DUTY-1:0] arm_new;
    logic                unused_data;

    assign arm_wr      = we_i && (addr_i == ADR_ARM);
    assign arm_new     = arm_wr ? wdata_i[NUM_DUTY:1] : '0;
    assign unused_data = &{1'b0, wdata_i};

    // Period register, written directly
    always_ff @(posedge clk) begin
        if (!rst_n)
            period_o <= CNT_W'(RST_PERIOD);
        else if (we_i && addr_i == ADR_PERIOD)
            period_o <= wdata_i[CNT_W-1:0];
    end

    // Duty shadow registers at addresses 1..NUM_DUTY
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_o <= '0;
        else if (we_i)
            for (int i = 0; i < NUM_DUTY; i++)
                if (addr_i == ADDR_W'(i + 1))
                    shadow_o[i] <= wdata_i[CNT_W-1:0];
    end

    // Arm bits: cleared by rollover, a same-edge write arms the next one
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm_o <= '0;
        else
            arm_o <= (rollover_i ? '0 : arm_o) | arm_new;
    end

    // Flag enables (bit 3n) and pin enables (bit 8+n)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_o <= '0;
            pin_en_o <= '0;
        end else if (we_i) begin
            if (addr_i == ADR_IRQ_EN)
                for (int n = 0; n <= NUM_DUTY; n++)
                    irq_en_o[n] <= wdata_i[3*n];
            if (addr_i == ADR_PIN_EN)
                for (int i = 0; i < NUM_DUTY; i++)
                    pin_en_o[i] <= wdata_i[9+i];
        end
    end

    // Decode write-one-to-clear pulses from the split flag layout
    for (genvar n = 0; n <= NUM_DUTY; n++) begin : g_clr
        localparam int FB = flag_bit(n);
        assign flag_clr_o[n] = we_i && (addr_i == ADR_FLAG_CLR) && wdata_i[FB];
    end

    assert_arm_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rollover_i && !arm_wr) |=> (arm_o == '0));
endmodule

// File: rtl/servo_timer_counter.sv
// Free-running tick counter that wraps to zero after reaching the period.
// Assumes one tick per clock; a period lowered below the count wraps at once.
module servo_timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             rollover_o
);
    assign rollover_o = (cnt_o >= period_i);

    // Count up, wrap on period match
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (rollover_o)
            cnt_o <= '0;
        else
            cnt_o <= cnt_o + 1'b1;
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rollover_o |=> (cnt_o == '0));
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rollover_o |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/servo_timer_channel.sv
// One duty channel: working duty register loaded from its shadow at an armed
// rollover, match detection, and the pin level for the current count.
// Assumes the count restarts at 0 on the cycle after rollover.
module servo_timer_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rollover_i,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] shadow_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             pin_en_i,
    output logic             pin_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] duty_q;

    // Working duty: copy the shadow only at an armed rollover
    always_ff @(posedge clk) begin
        if (!rst_n)
            duty_q <= '0;
        else if (rollover_i && arm_i)
            duty_q <= shadow_i;
    end

    assign hit_o = (cnt_i == duty_q);
    assign pin_o = pin_en_i && ((cnt_i < duty_q) || (duty_q >= period_i));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rollover_i |=> $stable(duty_q));
    assert_start_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rollover_i |=> (!pin_en_i || duty_q == '0 || pin_o));
endmodule

// File: rtl/servo_timer_irq.sv
// Match flags with per-flag enable, write-one-to-clear, set winning over
// clear, and the OR of enabled set flags as the interrupt request.
// Assumes hit_i[0] is the period match and hit_i[n] the duty match of channel n.
module servo_timer_irq
    import servo_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_DUTY:0] hit_i,
    input  logic [NUM_DUTY:0] en_i,
    input  logic [NUM_DUTY:0] clr_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              irq_o
);
    logic [NUM_DUTY:0] flag_q;
    logic [NUM_DUTY:0] set_req;

    assign set_req = hit_i & en_i;

    // Flag update: set has priority over a same-edge clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= set_req | (flag_q & ~clr_i);
    end

    assign irq_o = |(flag_q & en_i);

    // Place flags into the split layout, unused bits tied low
    always_comb begin
        flags_o = '0;
        for (int n = 0; n <= NUM_DUTY; n++)
            flags_o[flag_bit(n)] = flag_q[n];
    end

    for (genvar n = 0; n <= NUM_DUTY; n++) begin : g_chk
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_req[n] |=> flag_q[n]);
        assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[n] && !set_req[n]) |=> !flag_q[n]);
        assert_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_q[n] && !en_i[n]) |=> !flag_q[n]);
    end
endmodule

// File: rtl/servo_match_timer.sv
// Top of the servo match timer: register file, shared counter, six duty
// channels and the flag/interrupt logic.
// Assumes a clock of one tick per counter step; no prescaler inside.
module servo_match_timer
    import servo_timer_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RST_PERIOD = 19999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [NUM_DUTY-1:0] pwm_out,
    output logic [FLAG_W-1:0] match_flags,
    output logic              irq
);
    logic [CNT_W-1:0]               period;
    logic [NUM_DUTY-1:0][CNT_W-1:0] shadow;
    logic [NUM_DUTY-1:0]            arm;
    logic [NUM_DUTY:0]              irq_en;
    logic [NUM_DUTY-1:0]            pin_en;
    logic [NUM_DUTY:0]              flag_clr;
    logic [CNT_W-1:0]               cnt;
    logic                           rollover;
    logic [NUM_DUTY:0]              hit;

    servo_timer_regs #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)) i_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .wdata_i(reg_wdata),
        .we_i(reg_we), .rollover_i(rollover), .period_o(period),
        .shadow_o(shadow), .arm_o(arm), .irq_en_o(irq_en),
        .pin_en_o(pin_en), .flag_clr_o(flag_clr)
    );

    servo_timer_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .period_i(period),
        .cnt_o(cnt), .rollover_o(rollover)
    );

    assign hit[0] = rollover;

    for (genvar i = 0; i < NUM_DUTY; i++) begin : g_ch
        servo_timer_channel #(.CNT_W(CNT_W)) i_ch (
            .clk(clk), .rst_n(rst_n), .rollover_i(rollover), .arm_i(arm[i]),
            .shadow_i(shadow[i]), .cnt_i(cnt), .period_i(period),
            .pin_en_i(pin_en[i]), .pin_o(pwm_out[i]), .hit_o(hit[i+1])
        );
    end

    servo_timer_irq i_irq (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .en_i(irq_en),
        .clr_i(flag_clr), .flags_o(match_flags), .irq_o(irq)
    );

    assert_irq_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match_flags != '0));
endmodule

// File: tb/test_servo_match_timer.sv
module test_servo_match_timer;
    localparam int CLK_P = 10;
    localparam int PER   = 49;   // period value, 50 clocks per period
    localparam int D1A   = 20;
    localparam int D1B   = 35;
    localparam int D1C   = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [5:0]  pwm_out;
    logic [10:0] match_flags;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    int run_len  = 0;
    logic prev_pin = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    servo_match_timer i_servo_match_timer (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .pwm_out(pwm_out), .match_flags(match_flags), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write is taken at the next posedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    // Returns at the negedge where the count is 0 (just after a rollover)
    task automatic sync_start();
        wr(4'd10, 32'h1);
        while (!match_flags[0]) @(negedge clk);
    endtask

    // Monitor: measure channel 1 high runs and compare with the expected queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (pwm_out[0]) run_len++;
            else if (prev_pin) begin
                if (exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    check("R3/R4 pulse width", run_len, e);
                end
                run_len = 0;
            end
            prev_pin = pwm_out[0];
        end
    end

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int hi3, hi4, hi5, hi6, hi2;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pins", {26'd0, pwm_out}, 32'd0);
        check("R1 flags", {21'd0, match_flags}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pins after release", {26'd0, pwm_out}, 32'd0);

        wr(4'd0, PER);
        wr(4'd1, D1A);
        wr(4'd2, 10);
        wr(4'd3, 0);
        wr(4'd4, 60);
        wr(4'd5, PER);
        wr(4'd6, 10);
        wr(4'd9, 32'h3E00);        // pins for channels 1..5
        wr(4'd8, 32'h1);           // flag 0 enable
        wr(4'd7, 32'h7E);          // arm all

        // Scoreboard driver for channel 1 (R3, R4)
        @(posedge pwm_out[0]); exp_q.push_back(D1A);
        @(negedge clk); wr(4'd1, D1B);           // shadow only, not armed
        @(posedge pwm_out[0]); exp_q.push_back(D1A);
        repeat (5) @(negedge clk); wr(4'd7, 32'h2); // arm mid-pulse
        @(posedge pwm_out[0]); exp_q.push_back(D1B);
        repeat (5) @(negedge clk);
        wr(4'd1, D1C); wr(4'd7, 32'h2);            // mid-pulse write + arm
        @(posedge pwm_out[0]); exp_q.push_back(D1C);
        @(posedge pwm_out[0]); exp_q.push_back(D1C);
        while (exp_q.size() > 0) @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 0);

        // R4/R5/R6: one full period of pin levels
        sync_start();
        hi2 = 0; hi3 = 0; hi4 = 0; hi5 = 0; hi6 = 0;
        for (int i = 0; i <= PER; i++) begin
            hi2 += int'(pwm_out[1]); hi3 += int'(pwm_out[2]);
            hi4 += int'(pwm_out[3]); hi5 += int'(pwm_out[4]);
            hi6 += int'(pwm_out[5]);
            @(negedge clk);
        end
        check("R4 width ch2", hi2, 10);
        check("R5 duty 0 low", hi3, 0);
        check("R5 duty above period high", hi4, PER + 1);
        check("R5 duty equal period high", hi5, PER + 1);
        check("R6 disabled pin low", hi6, 0);

        // R7/R8/R10: flag layout and interrupt
        wr(4'd8, 32'h0000_8009);   // enables for match 0, 1, 5
        wr(4'd10, 32'h70F);
        sync_start();
        repeat (PER + 1) @(negedge clk);
        check("R8 R7 flag layout", {21'd0, match_flags}, 32'h203);
        check("R10 irq set", {31'd0, irq}, 32'd1);
        wr(4'd8, 32'h0);
        check("R10 irq off when disabled", {31'd0, irq}, 32'd0);
        wr(4'd10, 32'h0);
        check("R9 zero write keeps flags", {21'd0, match_flags}, 32'h203);
        wr(4'd10, 32'h200);
        check("R9 clear bit 9 only", {21'd0, match_flags}, 32'h003);
        wr(4'd10, 32'h70F);
        check("R9 clear all", {21'd0, match_flags}, 32'h0);
        repeat (PER + 2) @(negedge clk);
        check("R7 no set while disabled", {21'd0, match_flags}, 32'h0);

        // R9: set and clear on the same edge
        wr(4'd8, 32'h9);
        sync_start();
        wr(4'd10, 32'h2);                   // count now 1
        check("R9 flag1 cleared", {31'd0, match_flags[1]}, 32'd0);
        repeat (D1C - 1) @(negedge clk);    // count now D1C
        wr(4'd10, 32'h2);                   // taken on the match edge
        check("R9 set wins over clear", {31'd0, match_flags[1]}, 32'd1);
        wr(4'd10, 32'h2);
        check("R9 later clear works", {31'd0, match_flags[1]}, 32'd0);

        // R3: arm write on the rollover edge applies one period later
        wr(4'd2, 20);
        sync_start();
        repeat (PER) @(negedge clk);        // count now PER
        wr(4'd7, 32'h4);                    // taken on the wrap edge
        check("R2 wrapped to start", {31'd0, match_flags[0]}, 32'd1);
        repeat (15) @(negedge clk);
        check("R3 old duty kept one period", {31'd0, pwm_out[1]}, 32'd0);
        repeat (PER + 1) @(negedge clk);
        check("R3 new duty next period", {31'd0, pwm_out[1]}, 32'd1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule